// File: doc/BRIEF.md
# Paced Buffer-to-Stream Transfer Engine

This block drains a small internal byte buffer into a downstream consumer. Software programs it through a byte-wide register port that has a register pointer. It sets a 16-bit read address and a 16-bit count, enables data output in the control register, and then writes the trigger register. The engine reads one buffer byte at a time and offers it on a valid/ready stream. Each byte is offered at most once per programmable transfer period. The engine steps the read address up and the count down for every accepted byte.

Stream rule: an offer is a single-cycle request. The consumer must hold `m_ready` high in the cycle where `m_valid` is high if it wants that byte. A byte that is not taken in that cycle is not lost. The engine stops offering and keeps the read address and count, so the same byte is offered again after a `resume` pulse. The count register holds the length minus one, and the transfer ends when the count underflows to all-ones. Status flags are active-low. The block also combines the transfer-end, command and decode events into one interrupt request. A separate write port fills the buffer.

Top module: `hxfer_engine`

## Requirements
- R1: After reset the status register (pointer address 7) reads 0xFF, the control register (address 0) reads 0x00, the period register (address 9) reads 24, `irq` is low and `m_valid` is low.
- R2: A write with `reg_sel`=0 loads the 5-bit register pointer. Every data access (`reg_sel`=1 with `reg_wr` or `reg_rd`) uses the register at the pointer and then advances the pointer by one, wrapping from 31 to 0. Unmapped addresses read 0.
- R3: A write to the trigger register (address 5) starts a transfer only if control bit 1 (data-output enable) is set. Starting clears status bit 1 (data busy) to 0. With the enable bit clear, a trigger produces no offer and leaves status bit 1 at 1.
- R4: A transfer moves {count-high (addr 2), count-low (addr 1)} + 1 bytes. Each byte equals the buffer entry at read address {addr 4, addr 3} modulo the buffer depth. After each accepted byte the read address increments and the count decrements. After the transfer the count reads 0xFFFF and the read address has advanced by the length.
- R5: When the count underflows, status bit 5 (transfer end) becomes 0 and status bit 1 becomes 1. A write to the acknowledge register (address 6) returns status bit 5 to 1.
- R6: Consecutive offers are exactly P clocks apart when the consumer is ready, where P is the period register value (address 9), and a value of 0 acts as 1. The first offer follows the trigger by one clock.
- R7: A refused offer pauses the engine and no further offer appears. A `resume` pulse restarts it only while it is paused, control bit 1 is set and the count is nonzero. The remaining bytes then continue from the unchanged read address.
- R8: A control write with bit 1 clear aborts any transfer or pause, and status bit 1 reads 1. A control write with bit 0 (serial enable) clear leaves status bit 0 at 1.
- R9: `irq` is high exactly when a source enabled in control bits 4 (command), 5 (transfer end) or 6 (decode) has its status bit at the same position at 0. `cmd_evt` clears status bit 4 and `dec_evt` clears status bit 6. Writing address 8 with bit 4 or bit 6 set returns that status bit to 1.
- R10: The read-address bytes are written separately, and a write to the high byte (address 4) leaves the low byte (address 3) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0: pointer load, 1: data access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances pointer) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register at the pointer (combinational) |
| buf_we | input | 1 | Buffer fill write enable |
| buf_waddr | input | BUF_AW | Buffer fill address |
| buf_wdata | input | 8 | Buffer fill data |
| m_valid | output | 1 | Byte offered this cycle |
| m_ready | input | 1 | Consumer takes the offered byte |
| m_data | output | 8 | Offered byte |
| resume | input | 1 | Restart a paused transfer |
| cmd_evt | input | 1 | Command event pulse |
| dec_evt | input | 1 | Decode event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps lengths, start addresses (including a low-byte carry and a buffer wrap) and periods. A design that ends on a count of zero rather than on underflow would deliver one byte too few. A design that masks the address wrongly would emit the wrong bytes after the wrap. A pacer that is off by one would put the gaps one clock wide of P. A multi-hundred-byte run checks the borrow into the high count byte, which a design that ignores that byte would cut short. The bench refuses a byte mid-transfer to check that the engine stops offering and that a resume restarts it at the refused byte. It also checks that a resume after completion or after an abort does nothing, and that an abort or a trigger with output disabled leaves data busy set. Finally it checks each interrupt source against its enable, where a mismatched mask would raise or miss `irq`.

// File: rtl/hx_pkg.sv
package hx_pkg;
  localparam int PTR_W = 5;
  localparam logic [PTR_W-1:0] A_CTL    = 5'd0;
  localparam logic [PTR_W-1:0] A_CNT_LO = 5'd1;
  localparam logic [PTR_W-1:0] A_CNT_HI = 5'd2;
  localparam logic [PTR_W-1:0] A_RAD_LO = 5'd3;
  localparam logic [PTR_W-1:0] A_RAD_HI = 5'd4;
  localparam logic [PTR_W-1:0] A_TRIG   = 5'd5;
  localparam logic [PTR_W-1:0] A_XACK   = 5'd6;
  localparam logic [PTR_W-1:0] A_STAT   = 5'd7;
  localparam logic [PTR_W-1:0] A_EVACK  = 5'd8;
  localparam logic [PTR_W-1:0] A_PERIOD = 5'd9;
  // bit positions shared by control (enables) and status (active-low flags)
  localparam int B_SER  = 0;
  localparam int B_DOUT = 1;
  localparam int B_CMD  = 4;
  localparam int B_XEND = 5;
  localparam int B_DEC  = 6;
endpackage

// File: rtl/hx_buf_ram.sv
module hx_buf_ram #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hx_pacer.sv
module hx_pacer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          fire,
  input  logic [PW-1:0] period,
  output logic          slot
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            left_q <= '0;
    else if (restart)      left_q <= '0;
    else if (fire)         left_q <= (period > PW'(1)) ? period - PW'(1) : '0;
    else if (left_q != '0) left_q <= left_q - PW'(1);
  end

  assign slot = (left_q == '0);
endmodule

// File: rtl/hx_irq.sv
module hx_irq #(
  parameter logic [7:0] SRC_MASK = 8'h70
) (
  input  logic [7:0] stat_n,
  input  logic [7:0] enables,
  output logic       irq
);
  assign irq = |(~stat_n & enables & SRC_MASK);
endmodule

// File: rtl/hxfer_engine.sv
module hxfer_engine
  import hx_pkg::*;
#(
  parameter int         BUF_AW     = 4,
  parameter logic [7:0] PERIOD_RST = 8'd24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_waddr,
  input  logic [7:0]        buf_wdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  input  logic              resume,
  input  logic              cmd_evt,
  input  logic              dec_evt,
  output logic              irq
);
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       ctl_q, stat_q, period_q;
  logic [15:0]      cnt_q, radr_q;
  logic             xfer_on, paused;

  logic wr_en, acc_en, fire, refuse, last, trig_go, resume_go, slot;

  assign wr_en     = reg_sel & reg_wr;
  assign acc_en    = reg_sel & (reg_wr | reg_rd);
  assign fire      = m_valid & m_ready;
  assign refuse    = m_valid & ~m_ready;
  assign last      = (cnt_q == 16'd0);
  assign trig_go   = wr_en && (ptr_q == A_TRIG) && ctl_q[B_DOUT];
  assign resume_go = resume && paused && ctl_q[B_DOUT] && (cnt_q != 16'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr_q <= '0;
    else if (!reg_sel && reg_wr) ptr_q <= reg_wdata[PTR_W-1:0];
    else if (acc_en)           ptr_q <= ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= 8'h00;
      stat_q   <= 8'hFF;
      period_q <= PERIOD_RST;
      cnt_q    <= '0;
      radr_q   <= '0;
      xfer_on  <= 1'b0;
      paused   <= 1'b0;
    end else begin
      // engine step
      if (fire) begin
        radr_q <= radr_q + 16'd1;
        cnt_q  <= cnt_q - 16'd1;
        if (last) begin
          xfer_on        <= 1'b0;
          stat_q[B_XEND] <= 1'b0;
          stat_q[B_DOUT] <= 1'b1;
        end
      end else if (refuse) begin
        xfer_on <= 1'b0;
        paused  <= 1'b1;
      end
      if (resume_go) begin
        xfer_on <= 1'b1;
        paused  <= 1'b0;
      end
      // register writes
      if (wr_en) begin
        unique case (ptr_q)
          A_CTL: begin
            ctl_q <= reg_wdata;
            if (!reg_wdata[B_DOUT]) begin
              stat_q[B_DOUT] <= 1'b1;
              xfer_on        <= 1'b0;
              paused         <= 1'b0;
            end
            if (!reg_wdata[B_SER]) stat_q[B_SER] <= 1'b1;
          end
          A_CNT_LO: cnt_q[7:0]   <= reg_wdata;
          A_CNT_HI: cnt_q[15:8]  <= reg_wdata;
          A_RAD_LO: radr_q[7:0]  <= reg_wdata;
          A_RAD_HI: radr_q[15:8] <= reg_wdata;
          A_TRIG: begin
            if (ctl_q[B_DOUT]) begin
              stat_q[B_DOUT] <= 1'b0;
              xfer_on        <= 1'b1;
              paused         <= 1'b0;
            end
          end
          A_XACK: stat_q[B_XEND] <= 1'b1;
          A_EVACK: begin
            if (reg_wdata[B_CMD]) stat_q[B_CMD] <= 1'b1;
            if (reg_wdata[B_DEC]) stat_q[B_DEC] <= 1'b1;
          end
          A_PERIOD: period_q <= reg_wdata;
          default: ;
        endcase
      end
      // external events win over acknowledges in the same cycle
      if (cmd_evt) stat_q[B_CMD] <= 1'b0;
      if (dec_evt) stat_q[B_DEC] <= 1'b0;
    end
  end

  always_comb begin
    unique case (ptr_q)
      A_CTL:    reg_rdata = ctl_q;
      A_CNT_LO: reg_rdata = cnt_q[7:0];
      A_CNT_HI: reg_rdata = cnt_q[15:8];
      A_RAD_LO: reg_rdata = radr_q[7:0];
      A_RAD_HI: reg_rdata = radr_q[15:8];
      A_STAT:   reg_rdata = stat_q;
      A_PERIOD: reg_rdata = period_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  hx_pacer #(.PW(8)) u_pacer (
    .clk(clk), .rst_n(rst_n), .restart(trig_go | resume_go),
    .fire(fire), .period(period_q), .slot(slot)
  );

  hx_buf_ram #(.AW(BUF_AW)) u_ram (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(radr_q[BUF_AW-1:0]), .rdata(m_data)
  );

  hx_irq #(.SRC_MASK(8'h70)) u_irq (
    .stat_n(stat_q), .enables(ctl_q), .irq(irq)
  );

  assign m_valid = xfer_on & slot;
endmodule

// File: rtl/hx_chk.sv
module hx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        m_valid,
  input logic        m_ready,
  input logic        dout_en,
  input logic        dbusy_n,
  input logic        xend_n,
  input logic [2:0]  src_n,
  input logic        irq,
  input logic [15:0] radr,
  input logic [7:0]  period
);
  assert_valid_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (dout_en && !dbusy_n));

  assert_refusal_pauses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> !m_valid);

  assert_pacing_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && period > 8'd1) |=> !m_valid);

  assert_end_sets_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xend_n) |-> dbusy_n);

  assert_addr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> (radr == $past(radr) + 16'd1));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_n == 3'b111) |-> !irq);
endmodule

bind hxfer_engine hx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .dout_en(ctl_q[1]), .dbusy_n(stat_q[1]), .xend_n(stat_q[5]),
  .src_n(stat_q[6:4]), .irq(irq), .radr(radr_q), .period(period_q)
);

// File: tb/hxfer_engine_test.sv
module hxfer_engine_test;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic buf_we = 0;
  logic [AW-1:0] buf_waddr = 0;
  logic [7:0] buf_wdata = 0;
  logic m_valid, m_ready = 1'b1, resume = 0, cmd_evt = 0, dec_evt = 0, irq;
  logic [7:0] m_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hxfer_engine #(.BUF_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .resume(resume), .cmd_evt(cmd_evt), .dec_evt(dec_evt), .irq(irq)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return 8'((a % DEPTH) * 37 + 5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = {3'b0, a};
    @(negedge clk); reg_sel = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_sel = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = {3'b0, a};
    @(negedge clk); reg_wr = 0; reg_sel = 1; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; reg_sel = 0;
  endtask

  task automatic pulse_resume;
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0;
  endtask

  // count offers over n cycles (sampled at negedges)
  task automatic count_valid(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (m_valid) cnt++;
      @(negedge clk);
    end
  endtask

  // collect bytes; checks data and spacing (R4, R6)
  task automatic collect(input logic [15:0] start, input int first_idx, input int want,
                         input int per, input int cycles, output int got);
    int last_cyc;
    got = 0; last_cyc = -1;
    for (int c = 0; c < cycles; c++) begin
      if (m_valid && m_ready) begin
        check("R4 byte value", m_data, pat(start + 16'(first_idx + got)));
        if (last_cyc >= 0) check("R6 offer spacing", c - last_cyc, per);
        last_cyc = c;
        got++;
      end
      @(negedge clk);
    end
    check("R4 byte count", got, want);
  endtask

  task automatic run_xfer(input logic [15:0] start, input int len, input logic [7:0] per);
    logic [7:0] d;
    int got, eper;
    eper = (per == 0) ? 1 : int'(per);
    wr(9, per);
    wr(3, start[7:0]); wr(4, start[15:8]);
    wr(1, 8'(len - 1)); wr(2, 8'((len - 1) >> 8));
    wr(5, 8'h00);
    collect(start, 0, len, eper, len * eper + 12, got);
    rd(1, d); check("R4 count low after end", d, 8'hFF);
    rd(2, d); check("R4 count high after end", d, 8'hFF);
    rd(3, d); check("R4 addr low after end", d, 8'(start + 16'(len)));
    rd(4, d); check("R4 addr high after end", d, 8'((start + 16'(len)) >> 8));
    rd(7, d); check("R5 end flag low", d[5], 0); check("R5 busy idle", d[1], 1);
    check("R9 irq on end", irq, 1);
    wr(6, 8'h00);
    rd(7, d); check("R5 ack restores end flag", d[5], 1);
    check("R9 irq cleared by ack", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    int n, got;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); buf_we = 1; buf_waddr = AW'(i); buf_wdata = pat(16'(i));
    end
    @(negedge clk); buf_we = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0); check("R1 valid", m_valid, 0);
    rd(7, d); check("R1 status", d, 8'hFF);
    rd(0, d); check("R1 control", d, 8'h00);
    rd(9, d); check("R1 period", d, 24);

    // R2 pointer wrap and auto-increment
    wr(0, 8'h70);
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = 8'd31;
    @(negedge clk); reg_wr = 0; reg_sel = 1; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); #1 d2 = reg_rdata; reg_rd = 0; reg_sel = 0;
    check("R2 unmapped reads zero", d, 0);
    check("R2 pointer wraps to control", d2, 8'h70);
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = 8'd3;
    @(negedge clk); reg_sel = 1; reg_wdata = 8'h11;
    @(negedge clk); reg_wdata = 8'h22;
    @(negedge clk); reg_wr = 0; reg_sel = 0;
    rd(3, d); check("R2 first write lands at pointer", d, 8'h11);
    rd(4, d); check("R2 second write lands at pointer+1", d, 8'h22);

    // R10 separate address bytes
    wr(3, 8'h5A); wr(4, 8'h03);
    rd(3, d); check("R10 low kept", d, 8'h5A);
    rd(4, d); check("R10 high written", d, 8'h03);

    // R3 trigger ignored with output disabled
    wr(1, 8'h02); wr(2, 8'h00);
    wr(5, 8'h00);
    count_valid(30, n); check("R3 no offer when disabled", n, 0);
    rd(7, d); check("R3 busy stays idle", d[1], 1);

    // R8 serial enable clear
    wr(0, 8'h72);
    rd(7, d); check("R8 serial busy high", d[0], 1);

    // R4/R5/R6 sweep (control 0x72: output enabled, all sources enabled)
    for (int p = 0; p <= 3; p++)
      for (int len = 1; len <= 6; len++) begin
        run_xfer(16'h0000, len, 8'(p));
        run_xfer(16'h000D, len, 8'(p));
        run_xfer(16'h00FE, len, 8'(p));
      end
    run_xfer(16'h0007, 300, 8'd1);
    run_xfer(16'h0002, 3, 8'd24);

    // R7 resume after normal end has no effect
    pulse_resume;
    count_valid(20, n); check("R7 resume when idle ignored", n, 0);

    // R7 pause and resume
    wr(9, 8'd2); wr(3, 8'h00); wr(4, 8'h00); wr(1, 8'd4); wr(2, 8'd0);
    wr(5, 8'h00);
    collect(16'h0000, 0, 2, 2, 3, got);
    m_ready = 0;
    count_valid(12, n); check("R7 one refused offer then silence", n, 1);
    rd(7, d); check("R7 still busy while paused", d[1], 0);
    rd(3, d); check("R7 address holds at refused byte", d, 2);
    m_ready = 1;
    pulse_resume;
    collect(16'h0000, 2, 3, 2, 20, got);
    rd(7, d); check("R7 ends after resume", d[5], 0);
    wr(6, 8'h00);

    // R8 abort
    wr(1, 8'd7); wr(2, 8'd0); wr(5, 8'h00);
    repeat (3) @(negedge clk);
    wr(0, 8'h70);
    count_valid(30, n); check("R8 no offer after abort", n, 0);
    rd(7, d); check("R8 busy idle after abort", d[1], 1);
    check("R8 no end flag on abort", d[5], 1);
    pulse_resume;
    count_valid(20, n); check("R7 resume after abort ignored", n, 0);

    // R9 command and decode sources
    wr(0, 8'h30);
    check("R9 quiet", irq, 0);
    @(negedge clk); cmd_evt = 1; @(negedge clk); cmd_evt = 0;
    check("R9 command raises irq", irq, 1);
    rd(7, d); check("R9 command flag low", d[4], 0);
    wr(8, 8'h10);
    check("R9 command ack drops irq", irq, 0);
    @(negedge clk); dec_evt = 1; @(negedge clk); dec_evt = 0;
    check("R9 masked decode no irq", irq, 0);
    rd(7, d); check("R9 decode flag low", d[6], 0);
    wr(0, 8'h40);
    check("R9 enabling decode raises irq", irq, 1);
    wr(8, 8'h40);
    check("R9 decode ack drops irq", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule